// File: doc/BRIEF.md
# Buffered compare PWM timer channel

This block is one 16-bit timer channel that produces a pulse-width modulated waveform. An up-counter runs from zero. A period compare register sets where the counter wraps back to zero. A duty compare register sets where the output rises within each period. The output is driven low whenever the counter wraps, so it is high from just after the duty match until the end of the period.

Software writes the duty value through a buffer register. With buffering switched on, the buffer is copied into the duty register only at the wrap. A new duty value therefore takes effect cleanly at the start of the next period, and no partial pulse is produced. With buffering switched off, the duty register is written directly and the buffer is never copied.

The counter, period and duty registers can all be written directly. The live count can be read back at any time.

Top module: `pwm_chan_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the counter, period, duty and buffer registers to 0 and drives `wave_o` low. All of these are visible after that edge.
- R2: On each clock edge where `cnt_en` is high and no counter write is present, the counter changes. When `cnt_en` is low, the counter and `wave_o` hold their values.
- R3: When the counter equals the period register on an enabled edge, the counter becomes 0 at that edge. Otherwise it increments by 1. A period therefore spans period+1 enabled edges.
- R4: When the counter equals the duty register on an enabled edge, and does not equal the period register, `wave_o` is 1 after that edge. From reset with duty D < period P, `wave_o` is 1 exactly while the count is in D+1..P.
- R5: An enabled edge at which the counter equals the period register drives `wave_o` to 0 after that edge.
- R6: When the duty match and the period match occur on the same edge, the wrap wins and `wave_o` is 0. Duty equal to period therefore gives a constant low output.
- R7: If duty is greater than period, the duty match never occurs and `wave_o` stays 0.
- R8: With `buf_en` = 1, each enabled edge at which the counter wraps copies the buffer register into the duty register. The copy takes priority over a direct duty write at the same edge. The new duty governs the following period.
- R9: A buffer write leaves the current period's waveform unchanged. With `buf_en` = 0, the buffer is never copied into the duty register.
- R10: A direct write to the counter, period or duty register takes effect at the next clock edge. A counter write overrides counting at that edge.
- R11: `cnt_q` always shows the current counter register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; compare and copy events occur only on enabled edges |
| buf_en | input | 1 | 1: duty is loaded from the buffer at each wrap |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wd | input | 16 | Counter write data |
| per_we | input | 1 | Period register write strobe |
| per_wd | input | 16 | Period write data |
| duty_we | input | 1 | Duty register direct write strobe |
| duty_wd | input | 16 | Duty write data |
| shad_we | input | 1 | Buffer register write strobe |
| shad_wd | input | 16 | Buffer write data |
| cnt_q | output | 16 | Counter readback |
| wave_o | output | 1 | PWM waveform output |

## Verification
Every result is a single register stage away from its cause:
- Counter value, `wave_o` level and duty copy all change at the clock edge where the compare is seen.
- Each of them is observable half a cycle later.

The bench applies inputs just after a falling edge and samples on the next falling edge. Each comparison therefore sees exactly one rising edge of effect.

Expected count and level come from arithmetic on the number of enabled edges. The count after n edges is n mod (P+1). The level is 1 only for counts in D+1..P. The bench tracks the duty in force per period, and updates it when it sees the count return to zero with buffering on.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    localparam int unsigned CNT_W_DEFAULT = 16;

    // Compare events seen at one count edge
    typedef struct packed {
        logic wrap;   // counter equals period
        logic hit;    // counter equals duty
    } pwm_evt_t;

    typedef enum logic [1:0] {
        WAVE_HOLD = 2'd0,
        WAVE_RISE = 2'd1,
        WAVE_FALL = 2'd2
    } wave_act_t;

    // The wrap outranks the duty match
    function automatic wave_act_t pick_action(input pwm_evt_t e, input logic step);
        if (!step)  return WAVE_HOLD;
        if (e.wrap) return WAVE_FALL;
        if (e.hit)  return WAVE_RISE;
        return WAVE_HOLD;
    endfunction

endpackage

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter #(
    parameter int unsigned W = pwm_chan_pkg::CNT_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    assign wrap = (cnt == per);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + ONE;
        end
    end
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs #(
    parameter int unsigned W = pwm_chan_pkg::CNT_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         wrap,
    input  logic         buf_en,
    input  logic         per_we,
    input  logic [W-1:0] per_wd,
    input  logic         duty_we,
    input  logic [W-1:0] duty_wd,
    input  logic         shad_we,
    input  logic [W-1:0] shad_wd,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] per,
    output logic [W-1:0] duty,
    output logic [W-1:0] shad,
    output logic         hit
);
    logic xfer;

    assign xfer = step && wrap && buf_en;
    assign hit  = (cnt == duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            per <= '0;
        end else if (per_we) begin
            per <= per_wd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shad <= '0;
        end else if (shad_we) begin
            shad <= shad_wd;
        end
    end

    // A copy at the wrap outranks a direct write
    always_ff @(posedge clk) begin
        if (rst) begin
            duty <= '0;
        end else if (xfer) begin
            duty <= shad;
        end else if (duty_we) begin
            duty <= duty_wd;
        end
    end
endmodule

// File: rtl/pwm_chan_wave.sv
module pwm_chan_wave
    import pwm_chan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  pwm_evt_t evt,
    output logic     wave
);
    wave_act_t act;

    assign act = pick_action(evt, step);

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
        end else begin
            case (act)
                WAVE_RISE: wave <= 1'b1;
                WAVE_FALL: wave <= 1'b0;
                default:   wave <= wave;
            endcase
        end
    end
endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top
    import pwm_chan_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             buf_en,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wd,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wd,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wd,
    input  logic             shad_we,
    input  logic [CNT_W-1:0] shad_wd,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wave_o
);
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] shad_q;
    pwm_evt_t         evt;

    pwm_chan_counter #(.W(CNT_W)) cnt_u (
        .clk    (clk),
        .rst    (rst),
        .step   (cnt_en),
        .ld     (cnt_we),
        .ld_val (cnt_wd),
        .per    (per_q),
        .cnt    (cnt_q),
        .wrap   (evt.wrap)
    );

    pwm_chan_regs #(.W(CNT_W)) regs_u (
        .clk     (clk),
        .rst     (rst),
        .step    (cnt_en),
        .wrap    (evt.wrap),
        .buf_en  (buf_en),
        .per_we  (per_we),
        .per_wd  (per_wd),
        .duty_we (duty_we),
        .duty_wd (duty_wd),
        .shad_we (shad_we),
        .shad_wd (shad_wd),
        .cnt     (cnt_q),
        .per     (per_q),
        .duty    (duty_q),
        .shad    (shad_q),
        .hit     (evt.hit)
    );

    pwm_chan_wave wave_u (
        .clk  (clk),
        .rst  (rst),
        .step (cnt_en),
        .evt  (evt),
        .wave (wave_o)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic         cnt_we,
    input logic         buf_en,
    input logic [W-1:0] cnt_q,
    input logic         wave_o,
    input logic [W-1:0] per,
    input logic [W-1:0] duty,
    input logic [W-1:0] shad
);
    localparam logic [W-1:0] ONE = W'(1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && !wave_o && per == '0 && duty == '0 && shad == '0));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !cnt_we) |=> ($stable(cnt_q) && $stable(wave_o)));

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_we && cnt_q == per) |=> (cnt_q == '0));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_we && cnt_q != per) |=> (cnt_q == $past(cnt_q) + ONE));

    // R4
    rise_on_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_q == duty && cnt_q != per) |=> wave_o);

    // R5
    fall_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_q == per) |=> !wave_o);

    // R8
    copy_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && buf_en && cnt_q == per) |=> (duty == $past(shad)));
endmodule

bind pwm_chan_top pwm_chan_chk #(.W(CNT_W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .cnt_we (cnt_we),
    .buf_en (buf_en),
    .cnt_q  (cnt_q),
    .wave_o (wave_o),
    .per    (per_q),
    .duty   (duty_q),
    .shad   (shad_q)
);

// File: tb/pwm_chan_top_tb_top.sv
`timescale 1ns/1ps
module pwm_chan_top_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b0, buf_en = 1'b0;
    logic         cnt_we = 1'b0, per_we = 1'b0, duty_we = 1'b0, shad_we = 1'b0;
    logic [W-1:0] cnt_wd = '0, per_wd = '0, duty_wd = '0, shad_wd = '0;
    logic [W-1:0] cnt_q;
    logic         wave_o;

    int  vec_n  = 0;
    int  bad_n  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_chan_top #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .buf_en(buf_en),
        .cnt_we(cnt_we), .cnt_wd(cnt_wd), .per_we(per_we), .per_wd(per_wd),
        .duty_we(duty_we), .duty_wd(duty_wd), .shad_we(shad_we), .shad_wd(shad_wd),
        .cnt_q(cnt_q), .wave_o(wave_o)
    );

    // one rising edge, then sample at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cnt_we = 1'b0; per_we = 1'b0; duty_we = 1'b0; shad_we = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vec_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_wave(input int c, input int d, input int p);
        return (d < p) && (c > d) && (c <= p);
    endfunction

    task automatic do_reset();
        rst = 1'b1; cnt_en = 1'b0; buf_en = 1'b0;
        tick();
        rst = 1'b0;
        check(cnt_q == 0, "R1 count", int'(cnt_q), 0);
        check(wave_o == 1'b0, "R1 wave", int'(wave_o), 0);
    endtask

    task automatic setup(input int p, input int d, input int s, input bit be);
        do_reset();
        buf_en = be;
        per_we = 1'b1;  per_wd  = W'(p);
        duty_we = 1'b1; duty_wd = W'(d);
        shad_we = 1'b1; shad_wd = W'(s);
        tick();
    endtask

    initial begin
        int dper;
        int sm;
        @(negedge clk);
        tick();
        rst = 1'b0;
        check(cnt_q == 0 && wave_o == 1'b0, "R1", int'(cnt_q), 0);

        // Sweep period and duty: R2 R3 R4 R5 R6 R7 R11
        for (int p = 0; p < 8; p++) begin
            for (int d = 0; d < 10; d++) begin
                setup(p, d, 0, 1'b0);
                cnt_en = 1'b1;
                for (int n = 1; n <= 2 * (p + 1) + 1; n++) begin
                    int  c;
                    bit  w;
                    tick();
                    c = n % (p + 1);
                    w = exp_wave(c, d, p);
                    check(int'(cnt_q) == c, "R3/R11 count", int'(cnt_q), c);
                    if (d > p)
                        check(wave_o == w, "R7 wave", int'(wave_o), int'(w));
                    else if (d == p)
                        check(wave_o == w, "R6 wave", int'(wave_o), int'(w));
                    else if (w)
                        check(wave_o == w, "R4 wave", int'(wave_o), int'(w));
                    else
                        check(wave_o == w, "R5 wave", int'(wave_o), int'(w));
                end
                cnt_en = 1'b0;
            end
        end

        // Hold while disabled: R2
        setup(9, 3, 0, 1'b0);
        cnt_en = 1'b1;
        for (int n = 0; n < 5; n++) tick();
        cnt_en = 1'b0;
        for (int n = 0; n < 4; n++) begin
            tick();
            check(cnt_q == 5, "R2 hold count", int'(cnt_q), 5);
            check(wave_o == 1'b1, "R2 hold wave", int'(wave_o), 1);
        end

        // Direct counter write overrides counting: R10
        cnt_en = 1'b1; cnt_we = 1'b1; cnt_wd = 16'd8;
        tick();
        check(cnt_q == 8, "R10 counter write", int'(cnt_q), 8);
        per_we = 1'b1; per_wd = 16'd12;
        tick();
        check(cnt_q == 9, "R10 count after period write", int'(cnt_q), 9);
        for (int e = 10; e <= 13; e++) begin
            tick();
            check(int'(cnt_q) == e % 13, "R10 new period", int'(cnt_q), e % 13);
        end
        cnt_en = 1'b0;

        // Buffered duty with a mid-period buffer write: R8 R9
        setup(7, 2, 5, 1'b1);
        dper = 2; sm = 5;
        cnt_en = 1'b1;
        for (int n = 1; n <= 24; n++) begin
            if (n == 3) begin shad_we = 1'b1; shad_wd = 16'd6; end
            tick();
            if (n == 3) sm = 6;
            if (cnt_q == 0) dper = sm;
            if (n <= 7)
                check(wave_o == exp_wave(int'(cnt_q), dper, 7), "R9 buffered write held",
                      int'(wave_o), int'(exp_wave(int'(cnt_q), dper, 7)));
            else
                check(wave_o == exp_wave(int'(cnt_q), dper, 7), "R8 buffered duty",
                      int'(wave_o), int'(exp_wave(int'(cnt_q), dper, 7)));
        end
        cnt_en = 1'b0;

        // Copy beats a direct duty write at the wrap: R8
        setup(3, 1, 2, 1'b1);
        cnt_en = 1'b1;
        for (int n = 1; n <= 3; n++) tick();
        duty_we = 1'b1; duty_wd = 16'd0;
        tick();
        for (int n = 1; n <= 4; n++) begin
            tick();
            check(wave_o == exp_wave(int'(cnt_q), 2, 3), "R8 copy priority",
                  int'(wave_o), int'(exp_wave(int'(cnt_q), 2, 3)));
        end
        cnt_en = 1'b0;

        // Buffering off: no copy, direct duty write next clock: R9 R10
        setup(7, 2, 5, 1'b0);
        dper = 2;
        cnt_en = 1'b1;
        for (int n = 1; n <= 24; n++) begin
            if (n == 9) begin duty_we = 1'b1; duty_wd = 16'd6; end
            tick();
            if (n == 9) dper = 6;
            if (n <= 8)
                check(wave_o == exp_wave(int'(cnt_q), dper, 7), "R9 no copy",
                      int'(wave_o), int'(exp_wave(int'(cnt_q), dper, 7)));
            else
                check(wave_o == exp_wave(int'(cnt_q), dper, 7), "R10 direct duty",
                      int'(wave_o), int'(exp_wave(int'(cnt_q), dper, 7)));
        end
        cnt_en = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad_n++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
            $finish;
        end
    end
endmodule